// File: doc/BRIEF.md
# Edge-Timestamp Capture Channel

This block timestamps transitions on one asynchronous input pin. The pin is brought into the clock domain through a flop synchronizer. A selectable detector then picks out rising transitions, falling transitions, both, or none. Each qualifying transition copies the free-running timer value supplied on `timer_cnt` into a two-slot FIFO. The two slots are called the head and the tail. A two-bit occupancy code reports how many slots hold data, and it also marks an overrun.

The interrupt flag follows the occupancy code, not single transitions. A capture into an empty FIFO does not raise it. The capture that fills the tail slot does raise it, and so does every capture after that. Software can overwrite the occupancy code. Writing "one entry held" while the FIFO is empty makes the very first transition raise the flag. Software reads the head value and strobes `pop` to retire it. It clears the flag by writing a one, and it gates the request line with an enable.

Top module: `cap_channel`

## Requirements
- R1: `edge_sel` picks the qualifying transitions: 2'b00 none, 2'b01 low-to-high only, 2'b10 high-to-low only, 2'b11 both. A non-qualifying change of `cap_in` leaves `occ`, `cap_top`, `cap_bot` and `int_flag` unchanged.
- R2: Suppose a change of `cap_in` is first sampled at clock edge k. The stored value is then the `timer_cnt` present in the cycle just before edge k+2, and it is visible at the outputs after edge k+2.
- R3: A capture with `occ` = 2'b00 loads `cap_top`, sets `occ` to 2'b01 and does not raise `int_flag`.
- R4: A capture with `occ` = 2'b01 loads `cap_bot`, sets `occ` to 2'b10 and raises `int_flag`.
- R5: A capture with `occ` = 2'b10 or 2'b11 discards the head, moves the tail to the head, loads the tail, sets `occ` to 2'b11 and raises `int_flag`.
- R6: A `pop` pulse retires the head. From 2'b01 `occ` becomes 2'b00. From 2'b10 or 2'b11 the tail moves to the head and `occ` becomes 2'b01. From 2'b00 nothing changes.
- R7: A `sts_wr_en` pulse loads `occ` from `sts_wr_data` and leaves the stored values untouched. After 2'b01 is written into an empty FIFO, the first capture goes to the tail and raises `int_flag`.
- R8: A `flag_clr` pulse clears `int_flag`. A capture that would raise the flag in the same cycle wins, and the flag stays set.
- R9: `irq` is high exactly while `int_flag` is set and `irq_en` is high.
- R10: While `rst_n` is low, `occ` is 2'b00, `int_flag` and `irq` are low and both stored values are zero. The release of reset takes effect synchronously with `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_in | input | 1 | Asynchronous input being watched |
| timer_cnt | input | TW | Free-running timer value to timestamp with |
| edge_sel | input | 2 | Qualifying transition select |
| sts_wr_en | input | 1 | Strobe that loads the occupancy code |
| sts_wr_data | input | 2 | Occupancy code to load |
| pop | input | 1 | Retire the head entry |
| flag_clr | input | 1 | Write-one-to-clear of the interrupt flag |
| irq_en | input | 1 | Interrupt request enable |
| cap_top | output | TW | Head (oldest) stored timestamp |
| cap_bot | output | TW | Tail (newer) stored timestamp |
| occ | output | 2 | Occupancy code: 00 empty, 01 one, 10 two, 11 overrun |
| int_flag | output | 1 | Capture interrupt flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench first drives alternating levels in low-to-high mode, so the ignored high-to-low changes are told apart from the counted ones. It then switches to high-to-low mode and both-edges mode, and then to the off setting. Captures run through all four occupancy states. This separates the silent first entry from the flag-raising second one and exposes the head shift on overrun. The stored values are compared against the timer value taken two cycles after the change is driven, which pins down the synchronizer depth. Three further cases decide the priority questions: the occupancy preload before a first edge, a flag clear that lands in the same cycle as a capture, and a toggle of the enable while the flag is set.

// File: rtl/cap_pkg.sv
package cap_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;

  typedef enum logic [1:0] {
    OCC_EMPTY = 2'b00,
    OCC_ONE   = 2'b01,
    OCC_TWO   = 2'b10,
    OCC_OVR   = 2'b11
  } occ_e;

endpackage

// File: rtl/cap_rst_sync.sv
module cap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign chain_d[i] = 1'b1;
    end else begin : g_body
      assign chain_d[i] = chain_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_n_out = chain_q[LAST];

endmodule

// File: rtl/cap_edge_det.sv
module cap_edge_det
  import cap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       din,
  input  logic [1:0] mode,
  output logic       evt
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   last_q;
  logic                   lvl;
  logic                   rise;
  logic                   fall;

  // shift chain next state
  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_in
      assign sync_d[i] = din;
    end else begin : g_mid
      assign sync_d[i] = sync_q[i-1];
    end
  end

  assign lvl  = sync_q[LAST];
  assign rise = lvl & ~last_q;
  assign fall = ~lvl & last_q;

  always_comb begin
    unique case (edge_mode_e'(mode))
      EDGE_RISE: evt = rise;
      EDGE_FALL: evt = fall;
      EDGE_BOTH: evt = rise | fall;
      default:   evt = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= lvl;
    end
  end

endmodule

// File: rtl/cap_fifo2.sv
module cap_fifo2
  import cap_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_evt,
  input  logic [W-1:0] cap_val,
  input  logic         pop,
  input  logic         wr_en,
  input  logic [1:0]   wr_occ,
  output logic [W-1:0] top_q,
  output logic [W-1:0] bot_q,
  output logic [1:0]   occ_out,
  output logic         pair_evt
);

  occ_e         occ_q, occ_w, occ_p, occ_d;
  logic [W-1:0] top_d, bot_d;
  logic         top_we, bot_we, occ_we;

  // order inside one cycle: software write, then pop, then capture
  always_comb begin
    occ_w    = wr_en ? occ_e'(wr_occ) : occ_q;
    occ_p    = occ_w;
    top_d    = top_q;
    bot_d    = bot_q;
    top_we   = 1'b0;
    bot_we   = 1'b0;
    pair_evt = 1'b0;

    if (pop) begin
      case (occ_w)
        OCC_EMPTY: occ_p = OCC_EMPTY;
        OCC_ONE:   occ_p = OCC_EMPTY;
        default: begin
          occ_p  = OCC_ONE;
          top_d  = bot_q;
          top_we = 1'b1;
        end
      endcase
    end

    occ_d = occ_p;
    if (cap_evt) begin
      case (occ_p)
        OCC_EMPTY: begin
          top_d  = cap_val;
          top_we = 1'b1;
          occ_d  = OCC_ONE;
        end
        OCC_ONE: begin
          bot_d    = cap_val;
          bot_we   = 1'b1;
          occ_d    = OCC_TWO;
          pair_evt = 1'b1;
        end
        default: begin
          top_d    = bot_q;
          top_we   = 1'b1;
          bot_d    = cap_val;
          bot_we   = 1'b1;
          occ_d    = OCC_OVR;
          pair_evt = 1'b1;
        end
      endcase
    end

    occ_we = wr_en | pop | cap_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q <= '0;
      bot_q <= '0;
      occ_q <= OCC_EMPTY;
    end else begin
      if (top_we) top_q <= top_d;
      if (bot_we) bot_q <= bot_d;
      if (occ_we) occ_q <= occ_d;
    end
  end

  assign occ_out = occ_q;

endmodule

// File: rtl/cap_irq_flag.sv
module cap_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic mask_en,
  output logic flag_q,
  output logic irq
);

  logic flag_d;
  logic flag_we;

  always_comb begin
    flag_we = set | clr;
    flag_d  = set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_we) flag_q <= flag_d;
  end

  assign irq = flag_q & mask_en;

endmodule

// File: rtl/cap_channel.sv
module cap_channel #(
  parameter int TW          = 16,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_in,
  input  logic [TW-1:0] timer_cnt,
  input  logic [1:0]    edge_sel,
  input  logic          sts_wr_en,
  input  logic [1:0]    sts_wr_data,
  input  logic          pop,
  input  logic          flag_clr,
  input  logic          irq_en,
  output logic [TW-1:0] cap_top,
  output logic [TW-1:0] cap_bot,
  output logic [1:0]    occ,
  output logic          int_flag,
  output logic          irq
);

  logic rst_sync_n;
  logic cap_evt;
  logic pair_evt;

  cap_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  cap_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .din   (cap_in),
    .mode  (edge_sel),
    .evt   (cap_evt)
  );

  cap_fifo2 #(.W(TW)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cap_evt  (cap_evt),
    .cap_val  (timer_cnt),
    .pop      (pop),
    .wr_en    (sts_wr_en),
    .wr_occ   (sts_wr_data),
    .top_q    (cap_top),
    .bot_q    (cap_bot),
    .occ_out  (occ),
    .pair_evt (pair_evt)
  );

  cap_irq_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set     (pair_evt),
    .clr     (flag_clr),
    .mask_en (irq_en),
    .flag_q  (int_flag),
    .irq     (irq)
  );

endmodule

// File: rtl/cap_channel_chk.sv
module cap_channel_chk #(
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst_ni,
  input logic          cap_evt,
  input logic [TW-1:0] timer_cnt,
  input logic          pop,
  input logic          sts_wr_en,
  input logic          flag_clr,
  input logic          irq_en,
  input logic [TW-1:0] cap_top,
  input logic [TW-1:0] cap_bot,
  input logic [1:0]    occ,
  input logic          int_flag,
  input logic          irq
);

  AST_EMPTY_FILLS_HEAD: assert property (@(posedge clk) disable iff (!rst_ni)
    (occ == 2'b00 && cap_evt && !pop && !sts_wr_en && !int_flag)
      |=> (occ == 2'b01 && cap_top == $past(timer_cnt) && !int_flag)); // R3

  AST_SECOND_RAISES_FLAG: assert property (@(posedge clk) disable iff (!rst_ni)
    (occ == 2'b01 && cap_evt && !pop && !sts_wr_en)
      |=> (occ == 2'b10 && cap_bot == $past(timer_cnt) && int_flag)); // R4

  AST_OVERRUN_SHIFTS: assert property (@(posedge clk) disable iff (!rst_ni)
    (occ[1] && cap_evt && !pop && !sts_wr_en)
      |=> (occ == 2'b11 && cap_top == $past(cap_bot) && int_flag)); // R5

  AST_POP_FROM_OVERRUN: assert property (@(posedge clk) disable iff (!rst_ni)
    (occ == 2'b11 && pop && !cap_evt && !sts_wr_en)
      |=> (occ == 2'b01 && cap_top == $past(cap_bot))); // R6

  AST_CLEAR_WITHOUT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_ni)
    (flag_clr && !cap_evt) |=> !int_flag); // R8

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(irq) |-> (irq_en && int_flag)); // R9

endmodule

bind cap_channel cap_channel_chk #(.TW(TW)) u_chk (
  .clk       (clk),
  .rst_ni    (rst_sync_n),
  .cap_evt   (cap_evt),
  .timer_cnt (timer_cnt),
  .pop       (pop),
  .sts_wr_en (sts_wr_en),
  .flag_clr  (flag_clr),
  .irq_en    (irq_en),
  .cap_top   (cap_top),
  .cap_bot   (cap_bot),
  .occ       (occ),
  .int_flag  (int_flag),
  .irq       (irq)
);

// File: tb/cap_channel_tb.sv
module cap_channel_tb;

  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cap_in = 1'b0;
  logic [TW-1:0] tcnt = '0;
  logic [1:0]    edge_sel = 2'b01;
  logic          sts_wr_en = 1'b0;
  logic [1:0]    sts_wr_data = 2'b00;
  logic          pop = 1'b0;
  logic          flag_clr = 1'b0;
  logic          irq_en = 1'b1;
  logic [TW-1:0] cap_top, cap_bot;
  logic [1:0]    occ;
  logic          int_flag, irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // reference model state
  logic [TW-1:0] sb_q[$];
  int            mdl_occ = 0;
  bit            mdl_flag = 1'b0;
  event          mon_ev;
  string         mon_tag;

  always #4 clk = ~clk;
  always @(posedge clk) tcnt <= tcnt + 1'b1;

  cap_channel #(.TW(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .timer_cnt(tcnt),
    .edge_sel(edge_sel), .sts_wr_en(sts_wr_en), .sts_wr_data(sts_wr_data),
    .pop(pop), .flag_clr(flag_clr), .irq_en(irq_en),
    .cap_top(cap_top), .cap_bot(cap_bot), .occ(occ),
    .int_flag(int_flag), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    check(req, 32'(occ), 32'(mdl_occ));
    check(req, 32'(int_flag), 32'(mdl_flag));
    check("R9", 32'(irq), 32'(mdl_flag & irq_en));
  endtask

  // scoreboard monitor: compares the head against the oldest expected entry
  always @(mon_ev) begin
    if (sb_q.size() != 0) check(mon_tag, 32'(cap_top), 32'(sb_q.pop_front()));
  end

  // driver: change the input, predict the capture, optionally clear in the landing cycle
  task automatic drive(input logic v, input bit clr_at_land);
    bit            qual;
    logic [TW-1:0] exp;
    string         tag;
    @(negedge clk);
    case (edge_sel)
      2'b01:   qual = !cap_in && v;
      2'b10:   qual = cap_in && !v;
      2'b11:   qual = cap_in != v;
      default: qual = 1'b0;
    endcase
    cap_in = v;
    exp = tcnt + 2;
    @(negedge clk);
    @(negedge clk);
    if (clr_at_land) flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    if (!qual) tag = "R1";
    else if (mdl_occ == 0) tag = "R3";
    else if (mdl_occ == 1) tag = "R4";
    else tag = "R5";
    if (qual) begin
      if (sb_q.size() == 2) void'(sb_q.pop_front());
      sb_q.push_back(exp);
      if (mdl_occ == 0) begin
        mdl_occ = 1;
        check("R2", 32'(cap_top), 32'(exp));
      end else begin
        mdl_occ  = (mdl_occ == 1) ? 2 : 3;
        mdl_flag = 1'b1;
        check("R2", 32'(cap_bot), 32'(exp));
      end
    end else if (clr_at_land) begin
      mdl_flag = 1'b0;
    end
    check_state(clr_at_land ? "R8" : tag);
  endtask

  task automatic do_pop();
    @(negedge clk);
    mon_tag = (mdl_occ >= 2) ? "R6" : "R2";
    if (mdl_occ != 0) -> mon_ev;
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
    if (mdl_occ == 1) mdl_occ = 0;
    else if (mdl_occ >= 2) mdl_occ = 1;
    check_state("R6");
  endtask

  task automatic do_clear();
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    mdl_flag = 1'b0;
    check_state("R8");
  endtask

  task automatic write_occ(input logic [1:0] v);
    @(negedge clk);
    sb_q.delete();
    if (v != 2'b00) sb_q.push_back(cap_top);
    if (v[1]) sb_q.push_back(cap_bot);
    sts_wr_en = 1'b1;
    sts_wr_data = v;
    @(negedge clk);
    sts_wr_en = 1'b0;
    mdl_occ = int'(v);
    check_state("R7");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10", 32'(occ), 32'd0);
    check("R10", 32'(int_flag), 32'd0);
    check("R10", 32'(irq), 32'd0);
    check("R10", 32'(cap_top), 32'd0);
    check("R10", 32'(cap_bot), 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // low-to-high only
    drive(1'b1, 1'b0);   // empty -> one, silent
    drive(1'b0, 1'b0);   // ignored
    drive(1'b1, 1'b0);   // one -> two, flag
    irq_en = 1'b0;
    @(negedge clk);
    check_state("R9");
    irq_en = 1'b1;
    @(negedge clk);
    check_state("R9");
    do_clear();
    drive(1'b0, 1'b0);   // ignored
    drive(1'b1, 1'b0);   // overrun
    do_pop();            // 11 -> 01
    do_pop();            // 01 -> 00
    do_pop();            // empty, no effect

    // high-to-low only, then both
    edge_sel = 2'b10;
    drive(1'b0, 1'b0);   // empty -> one
    drive(1'b1, 1'b0);   // ignored
    edge_sel = 2'b11;
    drive(1'b0, 1'b0);   // one -> two
    do_clear();
    drive(1'b1, 1'b1);   // capture beats clear, overrun
    do_pop();
    do_pop();

    // preload one entry so the first edge raises the flag
    do_clear();
    write_occ(2'b01);
    drive(1'b0, 1'b0);
    do_pop();
    do_pop();

    // detector off
    edge_sel = 2'b00;
    drive(1'b1, 1'b0);
    drive(1'b0, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule